// File: doc/BRIEF.md
# Soft-Stepping Stereo Attenuation Controller

This block holds the gain state of a two-channel audio output path. Software supplies a 7-bit attenuation code per channel, where each count is 0.5 dB of cut. Code 0 is full level and code 127 is the deepest setting, which the block also uses as full mute. Each channel also has its own mute bit. The block does not jump to a new setting. On each qualified timing tick it moves each channel's applied code one count toward that channel's target, so gain changes reach the multiplier as smooth ramps. A completion flag tells software when both channels have arrived.

A separate sequencer guards against clicks. When the de-emphasis or bass-boost enable changes, it ramps both channels to mute. It then latches the new effect settings and issues a one-cycle apply strobe, and after that ramps back up. On power-up the channels start from mute and ramp up. On power-down they ramp to mute before the power-down output is raised. The base tick arrives every 20 µs. A slow-rate input uses only every second tick.

Top module: `soft_vol_ctrl`

## Requirements
- R1: After reset both applied codes are 127, `pwr_dn` is 1, and `done`, `fx_apply`, `deemph_act` and `bass_act` are 0.
- R2: While powered and not sequencing, each used tick moves each channel's applied code one count toward its target code. A channel already at its target stays there. The two channels move independently.
- R3: A channel's mute bit makes its target 127 whatever its volume code is.
- R4: An internal phase bit toggles on every `step_tick`. With `slow_rate` at 1, a tick is used only when the phase bit is set. Any two consecutive base ticks therefore give exactly one step. With `slow_rate` at 0, every tick is used.
- R5: `done` is 1 only when the block is powered, no sequence is running, the effect enables equal the applied effects, and both applied codes equal their targets.
- R6: A change on `deemph_en` or `bass_en` starts the effect sequence. Both channels ramp to 127 and `done` stays 0. In the cycle after both reach 127, `fx_apply` is high for exactly one cycle and `deemph_act`/`bass_act` take the new enables. The channels then ramp back to their targets.
- R7: When `power_on` rises while powered down, `pwr_dn` falls after one clock. The channels start at 127 and ramp toward their targets.
- R8: When `power_on` falls, the channels ramp to 127. `pwr_dn` rises in the cycle after both reach 127, and the codes are held at 127 while powered down.
- R9: A target that changes in the middle of a ramp is followed from the current applied code, with no restart.
- R10: Without a used tick, the applied codes do not change.
- R11: A power-down request during the effect sequence takes priority. The pending effects are not applied, `fx_apply` does not pulse, and the sequence resumes after the next power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_tick | input | 1 | One-cycle base step tick (20 µs) |
| slow_rate | input | 1 | 1: use every second tick |
| vol_l | input | 7 | Left target attenuation code |
| vol_r | input | 7 | Right target attenuation code |
| mute_l | input | 1 | Left mute |
| mute_r | input | 1 | Right mute |
| deemph_en | input | 1 | Requested de-emphasis enable |
| bass_en | input | 1 | Requested bass-boost enable |
| power_on | input | 1 | Power request |
| cur_l | output | 7 | Left applied attenuation code |
| cur_r | output | 7 | Right applied attenuation code |
| done | output | 1 | Ramp complete flag |
| fx_apply | output | 1 | One-cycle effect apply strobe |
| deemph_act | output | 1 | Applied de-emphasis enable |
| bass_act | output | 1 | Applied bass-boost enable |
| pwr_dn | output | 1 | Power-down state output |

## Verification
The effect sequence and a power-down request can be active in the same cycle. The bench provokes this by toggling the bass-boost enable and then, while the channels are still ramping to mute, dropping `power_on`. It judges the result by three observations: `pwr_dn` rises once both codes reach 127, `fx_apply` never pulses, and `bass_act` keeps its old value. It then confirms that the pending effect is applied right after the next power-up, before the channels ramp up.

// File: rtl/svc_pkg.sv
package svc_pkg;
  localparam int CODE_W = 7;
  localparam int NCH    = 2;
  localparam int NFX    = 2;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t MUTE_CODE = '1;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RUN  = 2'd1,
    ST_FXDN = 2'd2,
    ST_PWDN = 2'd3
  } seq_t;

  // Target code of one channel after mute and forced mute are applied.
  function automatic code_t pick_target(code_t vol, logic mute, logic force_mute);
    return (mute || force_mute) ? MUTE_CODE : vol;
  endfunction

  // One count toward the target, or none when already there.
  function automatic code_t step_toward(code_t cur, code_t tgt);
    if (cur < tgt)      return cur + code_t'(1);
    else if (cur > tgt) return cur - code_t'(1);
    else                return cur;
  endfunction
endpackage

// File: rtl/svc_tick_gate.sv
module svc_tick_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic step_tick,
  input  logic slow_rate,
  output logic use_tick
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         phase_q <= 1'b0;
    else if (step_tick) phase_q <= ~phase_q;
  end

  assign use_tick = step_tick && (!slow_rate || phase_q);

  // R4: in slow mode two back-to-back used ticks cannot occur
  p_slow_no_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_rate && use_tick) |=> !(slow_rate && use_tick));
  // R10: no base tick, no used tick
  p_tick_from_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !step_tick |-> !use_tick);
endmodule

// File: rtl/svc_ramp_chan.sv
module svc_ramp_chan
  import svc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  use_tick,
  input  logic  hold_mute,
  input  code_t tgt,
  output code_t cur,
  output logic  at_tgt,
  output logic  at_mute
);
  code_t cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cur_q <= MUTE_CODE;
    else if (hold_mute) cur_q <= MUTE_CODE;
    else if (use_tick)  cur_q <= step_toward(cur_q, tgt);
  end

  assign cur     = cur_q;
  assign at_tgt  = (cur_q == tgt);
  assign at_mute = (cur_q == MUTE_CODE);

  // R2: a used tick with the target not reached always moves the code
  p_tick_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (use_tick && !hold_mute && cur_q != tgt) |=> (cur_q != $past(cur_q)));
  // R2: never more than one count per cycle
  p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, cur_q} == {1'b0, $past(cur_q)} ||
              {1'b0, cur_q} == {1'b0, $past(cur_q)} + 8'd1 ||
              {1'b0, cur_q} + 8'd1 == {1'b0, $past(cur_q)}));
  // R10: with no used tick the code only moves to mute when held
  p_no_tick_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_tick && !hold_mute) |=> $stable(cur_q));
endmodule

// File: rtl/svc_seq.sv
module svc_seq
  import svc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           power_on,
  input  logic [NFX-1:0] fx_req,
  input  logic           all_at_tgt,
  input  logic           all_muted,
  output logic           force_mute,
  output logic           hold_off,
  output logic           done,
  output logic           fx_apply,
  output logic [NFX-1:0] fx_act,
  output logic           pwr_dn
);
  seq_t           st_q, st_d;
  logic [NFX-1:0] act_q;
  logic           apply_q;
  logic           fx_pending;
  logic           mute_reached;

  assign fx_pending   = (fx_req != act_q);
  assign mute_reached = all_muted;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:  if (power_on) st_d = ST_RUN;
      ST_RUN: begin
        if (!power_on)       st_d = ST_PWDN;
        else if (fx_pending) st_d = ST_FXDN;
      end
      ST_FXDN: begin
        if (!power_on)         st_d = ST_PWDN;
        else if (mute_reached) st_d = ST_RUN;
      end
      ST_PWDN: begin
        if (power_on)          st_d = ST_RUN;
        else if (mute_reached) st_d = ST_OFF;
      end
      default: st_d = ST_OFF;
    endcase
  end

  logic apply_now;
  assign apply_now = (st_q == ST_FXDN) && power_on && mute_reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      act_q   <= '0;
      apply_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      apply_q <= apply_now;
      if (apply_now) act_q <= fx_req;
    end
  end

  assign force_mute = (st_q == ST_FXDN) || (st_q == ST_PWDN);
  assign hold_off   = (st_q == ST_OFF);
  assign pwr_dn     = hold_off;
  assign fx_act     = act_q;
  assign fx_apply   = apply_q;
  assign done       = (st_q == ST_RUN) && power_on && !fx_pending && all_at_tgt;

  // R6: the apply strobe lasts one cycle
  p_apply_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fx_apply |=> !fx_apply);
  // R6: applied effects only change together with the strobe
  p_act_with_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fx_act != $past(fx_act)) |-> fx_apply);
  // R11: after a power drop no apply strobe follows
  p_power_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !power_on |=> !fx_apply);
endmodule

// File: rtl/soft_vol_ctrl.sv
module soft_vol_ctrl
  import svc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_tick,
  input  logic              slow_rate,
  input  logic [CODE_W-1:0] vol_l,
  input  logic [CODE_W-1:0] vol_r,
  input  logic              mute_l,
  input  logic              mute_r,
  input  logic              deemph_en,
  input  logic              bass_en,
  input  logic              power_on,
  output logic [CODE_W-1:0] cur_l,
  output logic [CODE_W-1:0] cur_r,
  output logic              done,
  output logic              fx_apply,
  output logic              deemph_act,
  output logic              bass_act,
  output logic              pwr_dn
);
  logic           use_tick;
  logic           force_mute, hold_off;
  logic [NFX-1:0] fx_act;
  code_t          vol_a [NCH];
  logic           mute_a [NCH];
  code_t          tgt_a [NCH];
  code_t          cur_a [NCH];
  logic [NCH-1:0] at_tgt, at_mute;

  assign vol_a[0]  = vol_l;
  assign vol_a[1]  = vol_r;
  assign mute_a[0] = mute_l;
  assign mute_a[1] = mute_r;

  svc_tick_gate u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_tick (step_tick),
    .slow_rate (slow_rate),
    .use_tick  (use_tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign tgt_a[c] = pick_target(vol_a[c], mute_a[c], force_mute);
    svc_ramp_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .use_tick  (use_tick),
      .hold_mute (hold_off),
      .tgt       (tgt_a[c]),
      .cur       (cur_a[c]),
      .at_tgt    (at_tgt[c]),
      .at_mute   (at_mute[c])
    );
  end

  svc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .power_on   (power_on),
    .fx_req     ({bass_en, deemph_en}),
    .all_at_tgt (&at_tgt),
    .all_muted  (&at_mute),
    .force_mute (force_mute),
    .hold_off   (hold_off),
    .done       (done),
    .fx_apply   (fx_apply),
    .fx_act     (fx_act),
    .pwr_dn     (pwr_dn)
  );

  assign cur_l      = cur_a[0];
  assign cur_r      = cur_a[1];
  assign deemph_act = fx_act[0];
  assign bass_act   = fx_act[1];

  // R8: while powered down both codes sit at mute
  p_pwrdn_muted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (cur_l == MUTE_CODE && cur_r == MUTE_CODE));
  // R6: effects are applied only from full mute
  p_apply_at_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fx_apply |-> (cur_l == MUTE_CODE && cur_r == MUTE_CODE));
  // R5/R3: done implies both codes equal the port-level targets
  p_done_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cur_l == (mute_l ? MUTE_CODE : vol_l) &&
              cur_r == (mute_r ? MUTE_CODE : vol_r)));
endmodule

// File: tb/sim_soft_vol_ctrl.sv
module sim_soft_vol_ctrl;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic step_tick = 0, slow_rate = 0, mute_l = 0, mute_r = 0;
  logic deemph_en = 0, bass_en = 0, power_on = 0;
  logic [6:0] vol_l = 7'd127, vol_r = 7'd127;
  logic [6:0] cur_l, cur_r;
  logic done, fx_apply, deemph_act, bass_act, pwr_dn;
  int checks = 0, errors = 0;

  always #(TCLK/2) clk = ~clk;

  soft_vol_ctrl u0 (.*);

  // vol_l, vol_r, mute_l, mute_r, ticks, exp_l, exp_r, exp_done
  localparam int NV = 6;
  localparam logic [38:0] VEC [NV] = '{
    {7'd120, 7'd125, 1'b0, 1'b0, 8'd10, 7'd120, 7'd125, 1'b1},
    {7'd100, 7'd125, 1'b0, 1'b0, 8'd5,  7'd115, 7'd125, 1'b0},
    {7'd100, 7'd0,   1'b0, 1'b1, 8'd3,  7'd112, 7'd127, 1'b0},
    {7'd110, 7'd0,   1'b0, 1'b1, 8'd4,  7'd110, 7'd127, 1'b1},
    {7'd110, 7'd126, 1'b1, 1'b0, 8'd1,  7'd111, 7'd126, 1'b0},
    {7'd111, 7'd126, 1'b0, 1'b0, 8'd0,  7'd111, 7'd126, 1'b1}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) step_tick = 1'b1;
      @(negedge clk) step_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cur_l", cur_l, 127);
    chk("R1 cur_r", cur_r, 127);
    chk("R1 pwr_dn", pwr_dn, 1);
    chk("R1 done", done, 0);
    chk("R1 fx_apply", fx_apply, 0);
    chk("R1 deemph_act", deemph_act, 0);

    // R7 power-up from mute
    power_on = 1'b1; vol_l = 7'd120; vol_r = 7'd125;
    @(negedge clk);
    chk("R7 pwr_dn low", pwr_dn, 0);
    chk("R7 start at mute", cur_l, 127);

    // Table walk: R2, R3, R5, R9, R10
    for (int v = 0; v < NV; v++) begin
      vol_l = VEC[v][38:32]; vol_r = VEC[v][31:25];
      mute_l = VEC[v][24];   mute_r = VEC[v][23];
      tick(int'(VEC[v][22:15]));
      @(negedge clk);
      chk($sformatf("R2/R3 vec%0d cur_l", v), cur_l, int'(VEC[v][14:8]));
      chk($sformatf("R2/R3 vec%0d cur_r", v), cur_r, int'(VEC[v][7:1]));
      chk($sformatf("R5 vec%0d done", v), done, int'(VEC[v][0]));
    end

    // R4 slow rate: two base ticks give one step
    slow_rate = 1'b1; vol_l = 7'd108;
    tick(2);
    chk("R4 slow two ticks", cur_l, 110);
    tick(2);
    chk("R4 slow four ticks", cur_l, 109);
    slow_rate = 1'b0;

    // R6 effect sequence
    deemph_en = 1'b1;
    @(negedge clk);
    chk("R6 done low in sequence", done, 0);
    tick(17);
    chk("R6 ramping to mute", cur_l, 126);
    chk("R6 right at mute", cur_r, 127);
    chk("R6 not applied yet", deemph_act, 0);
    chk("R6 done low mid", done, 0);
    tick(1);
    chk("R6 no strobe before", fx_apply, 0);
    @(negedge clk);
    chk("R6 strobe", fx_apply, 1);
    chk("R6 deemph applied", deemph_act, 1);
    @(negedge clk);
    chk("R6 strobe one cycle", fx_apply, 0);
    tick(1);
    chk("R6 ramp back", cur_l, 126);
    chk("R6 ramp back right", cur_r, 126);

    // R9 retarget mid-ramp
    vol_l = 7'd124;
    tick(1);
    chk("R9 first step", cur_l, 125);
    vol_l = 7'd126;
    tick(1);
    chk("R9 follow new target", cur_l, 126);

    // R11 power-down during effect sequence, R8 ramp down
    bass_en = 1'b1;
    @(negedge clk);
    power_on = 1'b0;
    @(negedge clk);
    chk("R8 not yet down", pwr_dn, 0);
    tick(1);
    @(negedge clk);
    chk("R8 pwr_dn after mute", pwr_dn, 1);
    chk("R8 held mute", cur_l, 127);
    chk("R11 no strobe", fx_apply, 0);
    chk("R11 bass not applied", bass_act, 0);
    tick(3);
    chk("R8 stays mute", cur_r, 127);

    // R7 + R11 power-up applies pending effect first
    power_on = 1'b1;
    @(negedge clk);
    chk("R7 pwr_dn falls", pwr_dn, 0);
    chk("R7 still mute", cur_l, 127);
    @(negedge clk);
    chk("R11 no strobe yet", fx_apply, 0);
    @(negedge clk);
    chk("R11 strobe after power-up", fx_apply, 1);
    chk("R11 bass applied", bass_act, 1);
    tick(1);
    chk("R7 ramp up", cur_l, 126);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule